// File: doc/BRIEF.md
# Shared Memory Bank Swizzle Mapper

This block turns a linear byte offset inside a tile row, plus the row number, into a permuted byte offset for a banked on-chip scratch memory. When consecutive rows are laid out the same way, accesses that walk down a column all land in the same bank. The mapper XORs the index of an aligned chunk with the low bits of the row number. Consecutive rows therefore rotate their chunks across the banks.

A 3-bit mode code picks the chunk (atom) size and the span inside which chunks are permuted. The supported combinations are:

- 16-byte chunks inside 32-, 64- or 128-byte spans.
- 32-byte chunks inside a 128-byte span.
- 64-byte chunks inside a 128-byte span.

One variant of the 32-byte mode also exchanges the two 8-byte halves of every 16-byte chunk on odd rows.

A separate flag reports an illegal setup. It covers an unknown mode code, a box row wider than the span, and a mode that does not fit the chosen interleave layout. The datapath is combinational. When `REG_OUT` is 1 the results pass through one output register stage.

Top module: `swz_map`

## Requirements
- R1: Mode 0 returns the offset unchanged. With interleave code 0 it is legal for any box width.
- R2: Modes 1, 2 and 3 XOR offset bit [4], bits [5:4] and bits [6:4] with row bits [0], [1:0] and [2:0] respectively. Offset bits [3:0] are unchanged.
- R3: Mode 4 XORs offset bits [6:5] with row bits [1:0]. Bits [4:0] are unchanged.
- R4: Mode 6 XORs offset bit [6] with row bit [0]. Bits [5:0] are unchanged.
- R5: Mode 5 applies the mode 4 mapping and also inverts offset bit [3] when row bit [0] is 1. Bits [2:0] and [4] are unchanged.
- R6: In every mode, offset bits at position 7 and above pass through unchanged.
- R7: With interleave code 0 (none) and a nonzero mode, the flag is raised when the box width in bytes exceeds the span. The span is 32 for mode 1, 64 for mode 2 and 128 for modes 3 to 6. A width equal to the span is legal.
- R8: With interleave code 2 (32-byte layout), every mode except 1 is illegal and the width limit does not apply. With code 1 (16-byte layout), no width limit applies.
- R9: Mode 7 and interleave code 3 raise the flag. Under mode 7 the offset passes through unchanged.
- R10: With `REG_OUT`=1, both outputs show the result of the inputs present at the previous rising clock edge. While reset is asserted, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Swizzle mode code |
| ilv_i | input | 2 | Interleave layout: 0 none, 1 16-byte, 2 32-byte, 3 reserved |
| row_i | input | ROW_W | Row index inside the tile |
| off_i | input | OFF_W | Linear byte offset |
| box_bytes_i | input | WID_W | Inner box width in bytes |
| off_o | output | OFF_W | Swizzled byte offset |
| illegal_o | output | 1 | Illegal configuration flag |

## Verification
Random offsets are applied with random row numbers and all eight mode codes, which tells apart the chunk fields of the modes. A mapping with the wrong field, the wrong number of row bits, or a missing half swap on odd rows fails at once.

Box widths are drawn around the span limits, and directed cases sit exactly at each span and one byte above it, which separates a "greater than" from a "greater or equal" comparison. Interleave codes are mixed in so that the 32-byte layout rule and the reserved code are told apart from the width rule.

A directed step checks the outputs just after the inputs change and before the next edge, which tells the registered variant apart from a combinational one.

// File: rtl/swz_pkg.sv
package swz_pkg;

  typedef struct packed {
    logic [2:0] span_lg;  // log2 of span bytes
    logic [2:0] atom_lg;  // log2 of chunk bytes
    logic       flip;     // swap 8-byte halves on odd rows
    logic       known;
  } swz_cfg_t;

  localparam logic [1:0] ILV_NONE = 2'd0;
  localparam logic [1:0] ILV_16   = 2'd1;
  localparam logic [1:0] ILV_32   = 2'd2;

endpackage

// File: rtl/swz_decode.sv
module swz_decode
  import swz_pkg::*;
(
  input  logic [2:0] mode_i,
  output swz_cfg_t   cfg_o
);
  always_comb begin
    cfg_o = '{span_lg: 3'd4, atom_lg: 3'd4, flip: 1'b0, known: 1'b1};
    unique case (mode_i)
      3'd0: ;
      3'd1: begin cfg_o.span_lg = 3'd5; cfg_o.atom_lg = 3'd4; end
      3'd2: begin cfg_o.span_lg = 3'd6; cfg_o.atom_lg = 3'd4; end
      3'd3: begin cfg_o.span_lg = 3'd7; cfg_o.atom_lg = 3'd4; end
      3'd4: begin cfg_o.span_lg = 3'd7; cfg_o.atom_lg = 3'd5; end
      3'd5: begin cfg_o.span_lg = 3'd7; cfg_o.atom_lg = 3'd5; cfg_o.flip = 1'b1; end
      3'd6: begin cfg_o.span_lg = 3'd7; cfg_o.atom_lg = 3'd6; end
      default: cfg_o.known = 1'b0;
    endcase
  end
endmodule

// File: rtl/swz_permute.sv
module swz_permute
  import swz_pkg::*;
#(
  parameter int OFF_W = 16,
  parameter int ROW_W = 8
) (
  input  swz_cfg_t           cfg_i,
  input  logic [ROW_W-1:0]   row_i,
  input  logic [OFF_W-1:0]   off_i,
  output logic [OFF_W-1:0]   off_o
);
  logic [2:0]       nbits;
  logic [2:0]       rsel;
  logic [OFF_W-1:0] xv;

  always_comb begin
    nbits = cfg_i.span_lg - cfg_i.atom_lg;
    rsel  = row_i[2:0] & 3'((4'd1 << nbits) - 4'd1);
    xv    = OFF_W'(rsel) << cfg_i.atom_lg;
    if (cfg_i.flip && row_i[0]) xv[3] = 1'b1;
    off_o = off_i ^ xv;
  end
endmodule

// File: rtl/swz_legal.sv
module swz_legal
  import swz_pkg::*;
#(
  parameter int WID_W = 16
) (
  input  swz_cfg_t         cfg_i,
  input  logic [2:0]       mode_i,
  input  logic [1:0]       ilv_i,
  input  logic [WID_W-1:0] box_bytes_i,
  output logic             illegal_o
);
  logic [WID_W:0] span_bytes;
  logic           too_wide;

  always_comb begin
    span_bytes = (WID_W+1)'(1) << cfg_i.span_lg;
    too_wide   = {1'b0, box_bytes_i} > span_bytes;
    illegal_o  = !cfg_i.known || (ilv_i == 2'd3);
    if (ilv_i == ILV_32 && mode_i != 3'd1) illegal_o = 1'b1;
    if (ilv_i == ILV_NONE && mode_i != 3'd0 && too_wide) illegal_o = 1'b1;
  end
endmodule

// File: rtl/swz_map.sv
module swz_map
  import swz_pkg::*;
#(
  parameter int OFF_W   = 16,
  parameter int ROW_W   = 8,
  parameter int WID_W   = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       mode_i,
  input  logic [1:0]       ilv_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [WID_W-1:0] box_bytes_i,
  output logic [OFF_W-1:0] off_o,
  output logic             illegal_o
);
  swz_cfg_t         cfg;
  logic [OFF_W-1:0] swz_off;
  logic             ill_c;

  swz_decode u_dec (.mode_i(mode_i), .cfg_o(cfg));

  swz_permute #(.OFF_W(OFF_W), .ROW_W(ROW_W)) u_perm (
    .cfg_i(cfg), .row_i(row_i), .off_i(off_i), .off_o(swz_off)
  );

  swz_legal #(.WID_W(WID_W)) u_leg (
    .cfg_i(cfg), .mode_i(mode_i), .ilv_i(ilv_i),
    .box_bytes_i(box_bytes_i), .illegal_o(ill_c)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          off_o     <= '0;
          illegal_o <= 1'b0;
        end else begin
          off_o     <= swz_off;
          illegal_o <= ill_c;
        end
      end
    end else begin : g_comb
      assign off_o     = swz_off;
      assign illegal_o = ill_c;
    end
  endgenerate

  always_comb begin
    if (mode_i == 3'd0)
      assert_mode0_ident_R1: assert (swz_off == off_i);
    if (mode_i inside {3'd1, 3'd2, 3'd3})
      assert_nibble_keep_R2: assert (swz_off[3:0] == off_i[3:0]);
    assert_high_keep_R6: assert (swz_off[OFF_W-1:7] == off_i[OFF_W-1:7]);
    if (ilv_i == 2'd2 && mode_i != 3'd1)
      assert_ilv32_flag_R8: assert (ill_c);
    if (mode_i == 3'd7)
      assert_unknown_mode_R9: assert (ill_c && swz_off == off_i);
  end
endmodule

// File: tb/swz_map_bench.sv
module swz_map_bench;
  localparam int OFF_W = 16;
  localparam int ROW_W = 8;
  localparam int WID_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [2:0]       mode;
  logic [1:0]       ilv;
  logic [ROW_W-1:0] row;
  logic [OFF_W-1:0] off;
  logic [WID_W-1:0] wid;
  logic [OFF_W-1:0] off_o;
  logic             ill_o;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  swz_map #(.OFF_W(OFF_W), .ROW_W(ROW_W), .WID_W(WID_W), .REG_OUT(1'b1)) u_swz_map (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .ilv_i(ilv), .row_i(row),
    .off_i(off), .box_bytes_i(wid), .off_o(off_o), .illegal_o(ill_o)
  );

  function automatic logic [OFF_W-1:0] exp_off(logic [2:0] m, logic [ROW_W-1:0] r, logic [OFF_W-1:0] o);
    logic [OFF_W-1:0] x = o;
    case (m)
      3'd1: x[4]   = x[4]   ^ r[0];
      3'd2: x[5:4] = x[5:4] ^ r[1:0];
      3'd3: x[6:4] = x[6:4] ^ r[2:0];
      3'd4: x[6:5] = x[6:5] ^ r[1:0];
      3'd5: begin x[6:5] = x[6:5] ^ r[1:0]; if (r[0]) x[3] = ~x[3]; end
      3'd6: x[6]   = x[6]   ^ r[0];
      default: ;
    endcase
    return x;
  endfunction

  function automatic logic exp_ill(logic [2:0] m, logic [1:0] i, logic [WID_W-1:0] w);
    int span;
    span = (m == 3'd1) ? 32 : (m == 3'd2) ? 64 : 128;
    if (m == 3'd7 || i == 2'd3) return 1'b1;
    if (i == 2'd2) return m != 3'd1;
    if (i == 2'd0 && m != 3'd0) return int'(w) > span;
    return 1'b0;
  endfunction

  function automatic string tag_of(logic [2:0] m);
    case (m)
      3'd0: return "R1";
      3'd1, 3'd2, 3'd3: return "R2";
      3'd4: return "R3";
      3'd5: return "R5";
      3'd6: return "R4";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic apply(logic [2:0] m, logic [1:0] i, logic [ROW_W-1:0] r,
                       logic [OFF_W-1:0] o, logic [WID_W-1:0] w, string req_ill);
    @(negedge clk);
    mode = m; ilv = i; row = r; off = o; wid = w;
    @(negedge clk);
    chk(tag_of(m), 32'(off_o), 32'(exp_off(m, r, o)));
    chk(req_ill, 32'(ill_o), 32'(exp_ill(m, i, w)));
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5a17));
    mode = 3'd3; ilv = 2'd3; row = 8'h5; off = 16'hffff; wid = 16'd999;
    #5;
    chk("R10 reset off", 32'(off_o), 32'h0);
    chk("R10 reset flag", 32'(ill_o), 32'h0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;

    apply(3'd0, 2'd0, 8'hff, 16'h1234, 16'd4000, "R1");
    apply(3'd1, 2'd0, 8'h01, 16'h00a0, 16'd32, "R7");
    apply(3'd1, 2'd0, 8'h01, 16'h00a0, 16'd33, "R7");
    apply(3'd2, 2'd0, 8'h03, 16'h0000, 16'd64, "R7");
    apply(3'd2, 2'd0, 8'h03, 16'h0000, 16'd65, "R7");
    apply(3'd6, 2'd0, 8'h01, 16'h0000, 16'd128, "R7");
    apply(3'd4, 2'd0, 8'h02, 16'h0000, 16'd129, "R7");
    apply(3'd5, 2'd0, 8'h01, 16'h0008, 16'd16, "R5");
    apply(3'd5, 2'd0, 8'h02, 16'h0008, 16'd16, "R5");
    apply(3'd3, 2'd0, 8'h07, 16'hff80, 16'd1, "R6");
    apply(3'd1, 2'd2, 8'h01, 16'h0010, 16'd300, "R8");
    apply(3'd3, 2'd2, 8'h01, 16'h0010, 16'd16, "R8");
    apply(3'd3, 2'd1, 8'h05, 16'h0010, 16'd500, "R8");
    apply(3'd7, 2'd0, 8'h05, 16'h0031, 16'd8, "R9");
    apply(3'd0, 2'd3, 8'h05, 16'h0031, 16'd8, "R9");

    // latency: new inputs must not reach outputs before the next rising edge
    @(negedge clk);
    mode = 3'd3; ilv = 2'd0; row = 8'h07; off = 16'h0070; wid = 16'd16;
    @(negedge clk);
    chk("R10 settle", 32'(off_o), 32'h0000);
    off = 16'h0000; mode = 3'd0;
    #1;
    chk("R10 hold", 32'(off_o), 32'h0000);
    @(negedge clk);
    chk("R10 next", 32'(off_o), 32'h0000);
    mode = 3'd1; row = 8'h01; off = 16'h0000;
    #1;
    chk("R10 hold2", 32'(off_o), 32'h0000);
    @(negedge clk);
    chk("R10 update", 32'(off_o), 32'h0010);

    for (int k = 0; k < 3000; k++) begin
      logic [1:0] iv;
      iv = ($urandom % 4 == 0) ? 2'($urandom) : 2'd0;
      apply(3'($urandom), iv, 8'($urandom), 16'($urandom),
            16'($urandom % 160), "R7");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule